// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block walks a synchronous DRAM through its mandatory start-up command chain once the supply and clock have settled. After reset it stays quiet until an external timer reports that the stabilization wait has run out. It then issues a single idle cycle, a precharge of every bank, two auto-refresh commands, an optional extended mode register load (double-data-rate parts only), and a mode register load. The gap that follows each command is a parameterized number of clock cycles, and the block emits NOP for every cycle of that gap.

The block emits the command to issue in each cycle as a 3-bit code. A neighbouring signal generator turns that code into the real address and command pins. When the final gap after the mode load has run out, the block raises a ready flag. That flag holds until the next reset, and the normal command engine waits on it before it starts traffic. The parameter `DDR_MODE` chooses between the double-data-rate chain and the single-data-rate chain, which has no extended mode load.

Top module: `sdram_init_seq`

## Requirements
- R1: With `rst_n` low at a clock edge, the next cycle shows `cmd` = NOP (0) and `init_done` low. Reset is synchronous and active low.
- R2: After reset and until `stable_done` has been sampled high on a clock edge, `cmd` stays NOP (0) and `init_done` stays low.
- R3: The cycle after the edge that first samples `stable_done` high is a NOP cycle. The cycle after that issues PRECHARGE-all, code 1, for exactly one cycle.
- R4: The first AUTO REFRESH, code 2, is issued exactly `T_RP` cycles after the PRECHARGE-all cycle.
- R5: The second AUTO REFRESH follows the first by exactly `T_RFC` cycles. The next command follows the second refresh by exactly `T_RFC` cycles.
- R6: With `DDR_MODE`=1, the command after the second refresh is the extended mode load, code 3, and the mode load, code 4, follows it by exactly `T_MRD` cycles. With `DDR_MODE`=0, the mode load comes directly after the second refresh and code 3 never appears.
- R7: `init_done` rises exactly `T_MRD` cycles after the mode load cycle and never earlier.
- R8: Once `init_done` is high it stays high until reset, and `cmd` stays NOP (0) from then on.
- R9: After the sequence has started, changes on `stable_done` have no effect on the command order, the timing, or `init_done`.
- R10: A reset asserted partway through the sequence returns the block to idle. It then waits for `stable_done` again and replays the full chain from the start.
- R11: In every cycle that is not one of the command cycles above, `cmd` is NOP (0), and `cmd` never takes a value above 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| stable_done | input | 1 | High when the external power/clock stabilization wait has ended |
| cmd | output | 3 | Command for this cycle: 0 NOP, 1 precharge-all, 2 auto refresh, 3 extended mode load, 4 mode load |
| init_done | output | 1 | High once the whole start-up chain has finished; sticky until reset |

## Verification
The bench builds two instances that share the same stimulus. The first is a double-data-rate build with `T_RP`=3, `T_RFC`=5 and `T_MRD`=2, so each of the three gaps has a distinct length, and a swapped or off-by-one gap shows up as a wrong command position. The second is a single-data-rate build with every gap set to 1, which drives the path that skips the wait states and lays all commands out on consecutive cycles. Random idle lengths before stabilization, random toggling of `stable_done` after the start, and resets at random points within the chain exercise the ignore and restart rules.

// File: rtl/sdram_init_pkg.sv
// Package: shared command codes and sequencer states for the SDRAM
// start-up sequencer. The command codes are decoded by the pin generator
// next to this block, so their values are fixed.
package sdram_init_pkg;

    typedef enum logic [2:0] {
        CMD_NOP      = 3'd0,
        CMD_PRE_ALL  = 3'd1,
        CMD_REFRESH  = 3'd2,
        CMD_EXT_MODE = 3'd3,
        CMD_MODE     = 3'd4
    } init_cmd_t;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_NOP,
        ST_PRE,
        ST_WAIT_RP,
        ST_REF1,
        ST_WAIT_RFC1,
        ST_REF2,
        ST_WAIT_RFC2,
        ST_EXT_MODE,
        ST_WAIT_EXT,
        ST_MODE,
        ST_WAIT_MODE,
        ST_READY
    } init_state_t;

    // Largest of three cycle counts, used to size the gap counter.
    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/sdram_init_gap_timer.sv
// Module: down-counter that times the NOP gap following a command.
// The FSM loads (gap - 1) in the command cycle and steps the counter in
// each wait cycle. `last` marks the final wait cycle. Assumes load_val >= 1
// whenever the FSM goes on to use the wait state.
module sdram_init_gap_timer #(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    input  logic          step,
    output logic          last
);

    logic [CW-1:0] cnt;

    // Load on a command cycle, count down while waiting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (step && (cnt != '0)) begin
            cnt <= cnt - 1'b1;
        end
    end

    // The final wait cycle is the one that sees a count of one.
    always_comb begin
        last = (cnt == CW'(1));
    end

endmodule

// File: rtl/sdram_init_fsm.sv
// Module: state machine for the start-up chain. It leaves idle only on
// the stabilization flag and then runs the fixed chain. The timer decides
// when each wait ends. A gap of 1 skips its wait state. Assumes every gap
// parameter is at least 1.
module sdram_init_fsm
    import sdram_init_pkg::*;
#(
    parameter int T_RP     = 3,
    parameter int T_RFC    = 5,
    parameter int T_MRD    = 2,
    parameter bit DDR_MODE = 1'b1,
    parameter int CW       = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          stable_done,
    input  logic          gap_last,
    output logic          gap_load,
    output logic [CW-1:0] gap_val,
    output logic          gap_step,
    output init_state_t   state
);

    localparam logic [CW-1:0] RP_LOAD  = CW'(T_RP - 1);
    localparam logic [CW-1:0] RFC_LOAD = CW'(T_RFC - 1);
    localparam logic [CW-1:0] MRD_LOAD = CW'(T_MRD - 1);
    localparam bit RP_SKIP  = (T_RP  <= 1);
    localparam bit RFC_SKIP = (T_RFC <= 1);
    localparam bit MRD_SKIP = (T_MRD <= 1);

    init_state_t state_nxt;
    init_state_t after_refresh;

    // Pick the variant: the double-data-rate chain inserts the extended mode load.
    generate
        if (DDR_MODE) begin : g_ddr_chain
            assign after_refresh = ST_EXT_MODE;
        end else begin : g_sdr_chain
            assign after_refresh = ST_MODE;
        end
    endgenerate

    // State register with synchronous reset to idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nxt;
        end
    end

    // Next state and gap timer control.
    always_comb begin
        state_nxt = state;
        gap_load  = 1'b0;
        gap_val   = '0;
        gap_step  = 1'b0;
        case (state)
            ST_IDLE: begin
                if (stable_done) state_nxt = ST_NOP;
            end
            ST_NOP: begin
                state_nxt = ST_PRE;
            end
            ST_PRE: begin
                gap_load  = 1'b1;
                gap_val   = RP_LOAD;
                state_nxt = RP_SKIP ? ST_REF1 : ST_WAIT_RP;
            end
            ST_WAIT_RP: begin
                gap_step = 1'b1;
                if (gap_last) state_nxt = ST_REF1;
            end
            ST_REF1: begin
                gap_load  = 1'b1;
                gap_val   = RFC_LOAD;
                state_nxt = RFC_SKIP ? ST_REF2 : ST_WAIT_RFC1;
            end
            ST_WAIT_RFC1: begin
                gap_step = 1'b1;
                if (gap_last) state_nxt = ST_REF2;
            end
            ST_REF2: begin
                gap_load  = 1'b1;
                gap_val   = RFC_LOAD;
                state_nxt = RFC_SKIP ? after_refresh : ST_WAIT_RFC2;
            end
            ST_WAIT_RFC2: begin
                gap_step = 1'b1;
                if (gap_last) state_nxt = after_refresh;
            end
            ST_EXT_MODE: begin
                gap_load  = 1'b1;
                gap_val   = MRD_LOAD;
                state_nxt = MRD_SKIP ? ST_MODE : ST_WAIT_EXT;
            end
            ST_WAIT_EXT: begin
                gap_step = 1'b1;
                if (gap_last) state_nxt = ST_MODE;
            end
            ST_MODE: begin
                gap_load  = 1'b1;
                gap_val   = MRD_LOAD;
                state_nxt = MRD_SKIP ? ST_READY : ST_WAIT_MODE;
            end
            ST_WAIT_MODE: begin
                gap_step = 1'b1;
                if (gap_last) state_nxt = ST_READY;
            end
            ST_READY: begin
                state_nxt = ST_READY;
            end
            default: begin
                state_nxt = ST_IDLE;
            end
        endcase
    end

endmodule

// File: rtl/sdram_init_cmd_enc.sv
// Module: maps the sequencer state to the command code for this cycle and
// to the ready flag. Every idle, lead-in and wait state maps to NOP. The
// module is purely combinational from the state register.
module sdram_init_cmd_enc
    import sdram_init_pkg::*;
(
    input  init_state_t state,
    output init_cmd_t   cmd,
    output logic        done
);

    // One command per command state, NOP elsewhere.
    always_comb begin
        case (state)
            ST_PRE:      cmd = CMD_PRE_ALL;
            ST_REF1:     cmd = CMD_REFRESH;
            ST_REF2:     cmd = CMD_REFRESH;
            ST_EXT_MODE: cmd = CMD_EXT_MODE;
            ST_MODE:     cmd = CMD_MODE;
            default:     cmd = CMD_NOP;
        endcase
    end

    // Ready only in the final resting state.
    always_comb begin
        done = (state == ST_READY);
    end

endmodule

// File: rtl/sdram_init_seq.sv
// Module: top of the SDRAM start-up sequencer. It connects the state
// machine, the gap timer and the command encoder. It assumes stable_done
// comes from the same clock domain and that every gap is at least 1.
module sdram_init_seq
    import sdram_init_pkg::*;
#(
    parameter int T_RP     = 3,
    parameter int T_RFC    = 5,
    parameter int T_MRD    = 2,
    parameter bit DDR_MODE = 1'b1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       stable_done,
    output logic [2:0] cmd,
    output logic       init_done
);

    localparam int TMAX = max3(T_RP, T_RFC, T_MRD);
    localparam int CW   = (TMAX < 2) ? 1 : $clog2(TMAX);

    init_state_t   state;
    init_cmd_t     cmd_enc;
    logic          gap_load;
    logic          gap_step;
    logic          gap_last;
    logic [CW-1:0] gap_val;

    sdram_init_fsm #(
        .T_RP     (T_RP),
        .T_RFC    (T_RFC),
        .T_MRD    (T_MRD),
        .DDR_MODE (DDR_MODE),
        .CW       (CW)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .stable_done (stable_done),
        .gap_last    (gap_last),
        .gap_load    (gap_load),
        .gap_val     (gap_val),
        .gap_step    (gap_step),
        .state       (state)
    );

    sdram_init_gap_timer #(
        .CW (CW)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (gap_load),
        .load_val (gap_val),
        .step     (gap_step),
        .last     (gap_last)
    );

    sdram_init_cmd_enc u_enc (
        .state (state),
        .cmd   (cmd_enc),
        .done  (init_done)
    );

    // Present the typed command as a plain vector at the port.
    assign cmd = cmd_enc;

endmodule

// File: rtl/sdram_init_seq_chk.sv
// Module: protocol checker for the start-up sequencer. It watches the
// ports only, keeps its own record of the last command and the cycles
// since that command, and is attached to every top-level instance.
module sdram_init_seq_chk #(
    parameter int T_RP     = 3,
    parameter int T_RFC    = 5,
    parameter int T_MRD    = 2,
    parameter bit DDR_MODE = 1'b1
) (
    input logic       clk,
    input logic       rst_n,
    input logic       stable_done,
    input logic [2:0] cmd,
    input logic       init_done
);

    localparam int TMAX = sdram_init_pkg::max3(T_RP, T_RFC, T_MRD);
    localparam int SW   = $clog2(TMAX + 2) + 1;
    localparam logic [2:0] C_NOP = 3'd0, C_PRE = 3'd1, C_REF = 3'd2,
                           C_EXT = 3'd3, C_MODE = 3'd4;

    logic          seen_stable;
    logic [2:0]    last_cmd;
    logic [SW-1:0] since;

    // Record whether stabilization has been sampled since reset.
    always_ff @(posedge clk) begin
        if (!rst_n)           seen_stable <= 1'b0;
        else if (stable_done) seen_stable <= 1'b1;
    end

    // Track the last command and a saturating cycle count since it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_cmd <= C_NOP;
            since    <= '0;
        end else if (cmd != C_NOP) begin
            last_cmd <= cmd;
            since    <= SW'(1);
        end else if (since != '1) begin
            since <= since + 1'b1;
        end
    end

    p_reset_idle_r1: assert property (@(posedge clk)
        !rst_n |=> (cmd == C_NOP && !init_done));

    p_quiet_before_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !seen_stable |-> (cmd == C_NOP && !init_done));

    p_pre_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd != C_NOP && last_cmd == C_PRE) |-> (cmd == C_REF && since == SW'(T_RP)));

    p_refresh_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd != C_NOP && last_cmd == C_REF) |-> (since == SW'(T_RFC)));

    p_mode_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd != C_NOP && last_cmd == C_EXT) |-> (cmd == C_MODE && since == SW'(T_MRD)));

    p_no_ext_in_sdr_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !DDR_MODE |-> (cmd != C_EXT));

    p_done_delay_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(init_done) |-> (last_cmd == C_MODE && since == SW'(T_MRD)));

    p_done_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |=> init_done);

    p_silent_when_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |-> (cmd == C_NOP));

    p_legal_code_r11: assert property (@(posedge clk) disable iff (!rst_n)
        cmd <= C_MODE);

endmodule

bind sdram_init_seq sdram_init_seq_chk #(
    .T_RP     (T_RP),
    .T_RFC    (T_RFC),
    .T_MRD    (T_MRD),
    .DDR_MODE (DDR_MODE)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .stable_done (stable_done),
    .cmd         (cmd),
    .init_done   (init_done)
);

// File: tb/test_sdram_init_seq.sv
// Bench: two sequencer builds (DDR with distinct gaps, SDR with unit gaps)
// driven by the same random plus directed stimulus. Expected commands
// come from an offset model of the chain.
module test_sdram_init_seq;

    localparam int CLK_PERIOD = 10;
    localparam int A_RP = 3, A_RFC = 5, A_MRD = 2;
    localparam int B_RP = 1, B_RFC = 1, B_MRD = 1;
    localparam int SPAN = 26;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       stable_done = 1'b0;
    logic [2:0] cmd_a, cmd_b;
    logic       done_a, done_b;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sdram_init_seq #(.T_RP(A_RP), .T_RFC(A_RFC), .T_MRD(A_MRD), .DDR_MODE(1'b1)) i_sdram_init_seq (
        .clk(clk), .rst_n(rst_n), .stable_done(stable_done), .cmd(cmd_a), .init_done(done_a));

    sdram_init_seq #(.T_RP(B_RP), .T_RFC(B_RFC), .T_MRD(B_MRD), .DDR_MODE(1'b0)) i_sdram_init_seq_sdr (
        .clk(clk), .rst_n(rst_n), .stable_done(stable_done), .cmd(cmd_b), .init_done(done_b));

    // Expected command i cycles after the edge that first saw stable_done.
    function automatic logic [2:0] exp_cmd(int i, int trp, int trfc, int tmrd, bit ddr);
        int o_ref1, o_ref2, o_ext, o_mode;
        o_ref1 = 1 + trp;
        o_ref2 = o_ref1 + trfc;
        o_ext  = o_ref2 + trfc;
        o_mode = ddr ? o_ext + tmrd : o_ref2 + trfc;
        if (i == 1) return 3'd1;
        if (i == o_ref1 || i == o_ref2) return 3'd2;
        if (ddr && i == o_ext) return 3'd3;
        if (i == o_mode) return 3'd4;
        return 3'd0;
    endfunction

    // Expected ready flag i cycles after the start edge.
    function automatic logic exp_done(int i, int trp, int trfc, int tmrd, bit ddr);
        int o_rdy;
        o_rdy = 1 + trp + 2 * trfc + tmrd + (ddr ? tmrd : 0);
        return (i >= o_rdy);
    endfunction

    // Name of the requirement that governs expected code at index i.
    function automatic string req_of(logic [2:0] c, logic d, int i);
        if (d) return "R8";
        case (c)
            3'd1: return "R3";
            3'd2: return (i <= 6) ? "R4" : "R5";
            3'd3: return "R6";
            3'd4: return "R6";
            default: return (i == 0) ? "R3" : "R11";
        endcase
    endfunction

    task automatic check(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d time=%0t", req, what, act, exp, $time);
        end
    endtask

    // Compare both instances at offset i (called at a falling edge).
    task automatic check_step(int i, string tag);
        logic [2:0] ea, eb;
        logic da, db;
        ea = exp_cmd(i, A_RP, A_RFC, A_MRD, 1'b1);
        eb = exp_cmd(i, B_RP, B_RFC, B_MRD, 1'b0);
        da = exp_done(i, A_RP, A_RFC, A_MRD, 1'b1);
        db = exp_done(i, B_RP, B_RFC, B_MRD, 1'b0);
        check((tag != "") ? tag : req_of(ea, da, i), "ddr cmd", cmd_a, ea);
        check((tag != "") ? tag : (da ? "R7" : req_of(ea, da, i)), "ddr done", done_a, da);
        check((tag != "") ? tag : req_of(eb, db, 2), "sdr cmd", cmd_b, eb);
        check((tag != "") ? tag : (db ? "R7" : "R6"), "sdr done", done_b, db);
    endtask

    // Both instances must be idle with no command.
    task automatic check_idle(string req);
        check(req, "ddr cmd idle", cmd_a, 0);
        check(req, "ddr done idle", done_a, 0);
        check(req, "sdr cmd idle", cmd_b, 0);
        check(req, "sdr done idle", done_b, 0);
    endtask

    task automatic do_reset(int len);
        rst_n = 1'b0;
        stable_done = 1'b0;
        for (int k = 0; k < len; k++) begin
            @(negedge clk);
            check_idle("R1");
        end
        rst_n = 1'b1;
    endtask

    // Full run: idle wait, stabilization, chain, random toggling afterwards.
    task automatic run_seq(int idle_len, bit toggle, int stop_at);
        for (int k = 0; k < idle_len; k++) begin
            @(negedge clk);
            check_idle("R2");
        end
        stable_done = 1'b1;
        for (int i = 0; i < SPAN; i++) begin
            @(negedge clk);
            if (stop_at >= 0 && i == stop_at) return;
            check_step(i, (toggle && i > 0) ? "" : "");
            if (toggle) stable_done = 1'($urandom % 2); // R9: ignored after start
        end
    endtask

    initial begin
        void'($urandom(32'd20240611));
        stable_done = 1'b0;
        rst_n = 1'b0;
        // R1: reset state
        do_reset(3);
        // Directed: short idle, stable held high throughout
        run_seq(2, 1'b0, -1);
        // Directed: R9 stable toggles randomly after start, zero idle
        do_reset(1);
        run_seq(0, 1'b1, -1);
        // Random runs with mid-sequence reset (R10) and restart
        for (int r = 0; r < 6; r++) begin
            int cut;
            cut = 1 + int'($urandom % 16);
            do_reset(1 + int'($urandom % 3));
            run_seq(int'($urandom % 12), 1'b1, cut);
            // R10: reset mid-chain returns to idle and waits for stable again
            rst_n = 1'b0;
            stable_done = 1'b0;
            @(negedge clk);
            check_idle("R10");
            rst_n = 1'b1;
            for (int k = 0; k < 3; k++) begin
                @(negedge clk);
                check_idle("R10");
            end
            run_seq(int'($urandom % 5), r[0], -1);
        end
        finished = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(CLK_PERIOD * 100000);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL R11 watchdog actual=%0d expected=%0d", 0, 1);
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule